// File: doc/BRIEF.md
# Register-Driven Serial Flash Word Engine

This block is the shifting core of a half-duplex serial flash controller. A host writes a small register file: a clock control word, a per-device control word, a command word and up to four 32-bit data words. Every accepted command moves exactly one word of 1 to 128 bits on the serial pins. The word is either written on one data line or read on one, two or four data lines. The host then polls a status word until the word is reported complete.

A frame groups several word commands under one chip select. The first transfer command of a frame latches the chip select index and the frame length. The select stays active until that many words have moved or until the host issues an end-of-frame command. Each chip select has its own clock polarity, clock phase and select polarity settings. The serial clock comes from a programmable divider of the functional clock and can be paused at any time.

Register word addresses: 0 clock control, 1 device control, 2 command, 3 status (read only), 4 to 7 data words 0 to 3.

Top module: `spw_word_engine`

## Requirements
- R1: After reset every chip select output is high (inactive, active-low default), the serial clock is low, the data line driver is off, and the status word reads 0.
- R2: Command word layout: [29:28] chip select index, [25:19] word length minus one, [18:16] operation, [11:0] frame length minus one. Operation 1 is a 1-line read, 2 a 1-line write, 3 a 2-line read and 7 a 4-line read. Any other code except 4 is ignored.
- R3: Clock control has its enable at bit 31 and a divider D in [15:0]. A serial clock period lasts D+1 functional cycles; D=0 acts as D=1. The first half of the period takes the larger share. Clearing the enable freezes the serial clock and the transfer where they stand.
- R4: A write word of L bits sends the low L bits of {data3,data2,data1,data0} on line 0, most significant bit first, one bit per clock. Line 0 is driven only during write words.
- R5: A read takes ceil(L/n) clocks, where n is 1, 2 or 4. A 1-line read samples line 1. A 2-line read shifts in {line1,line0} each clock; a 4-line read shifts in {line3..line0}. The bits are taken MSB first and land right-aligned in {data3..data0}, with the bits above cleared.
- R6: Device control gives chip select i the byte at 8*i: bit 0 clock polarity, bit 1 select polarity (1 = active high), bit 2 clock phase. The idle clock level equals the polarity. Input is sampled at the mid-period clock transition. Phase 1 swaps the half levels, so output data changes on the leading edge.
- R7: A frame asserts the select latched at its first command, keeps it asserted between words, and releases it after frame-length words. At most one select is active at a time.
- R8: Command code 4, accepted when not busy, releases the select on the next cycle and ends the frame.
- R9: Status bit 0 is busy and bit 1 is word-complete. Word-complete rises as busy falls at the end of a word. It clears when the next transfer command is accepted.
- R10: While busy, command, device control and data word writes are ignored. Reading back the command and data words shows the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | NUM_CS | Chip select levels |
| io0_o | output | 1 | Line 0 output data |
| io0_oe | output | 1 | Line 0 output enable |
| io_i | input | 4 | Data line inputs, lines 3..0 |

## Verification
Several properties are checked on every cycle: at most one select is active, word-complete and busy never overlap, and word-complete rises only as busy falls. The clock holds while the enable is off, the end-of-frame command releases every select, and line 0 is never driven without a select. Other behaviour depends on data, so only the bench scenarios can show it. This covers bit order on the line and lane packing of 2- and 4-line reads. It also covers clock period for a given divider, frames that span several words, and writes that are dropped while busy. A behavioural model in the bench follows every clock for these.

// File: rtl/spw_pkg.sv
package spw_pkg;
    typedef enum logic [2:0] {
        RA_CLK  = 3'd0,
        RA_DEV  = 3'd1,
        RA_CMD  = 3'd2,
        RA_STAT = 3'd3,
        RA_D0   = 3'd4,
        RA_D1   = 3'd5,
        RA_D2   = 3'd6,
        RA_D3   = 3'd7
    } reg_addr_e;

    localparam logic [2:0] OP_RD1 = 3'd1;
    localparam logic [2:0] OP_WR1 = 3'd2;
    localparam logic [2:0] OP_RD2 = 3'd3;
    localparam logic [2:0] OP_END = 3'd4;
    localparam logic [2:0] OP_RD4 = 3'd7;

    localparam int CMD_CS_LSB = 28;
    localparam int CMD_WL_LSB = 19;
    localparam int CMD_OP_LSB = 16;
    localparam int CLK_EN_BIT = 31;
    localparam int LANE_W     = 8;
    localparam int LANE_CPOL  = 0;
    localparam int LANE_CSPOL = 1;
    localparam int LANE_CPHA  = 2;

    function automatic logic [2:0] lanes_of(logic [2:0] op);
        case (op)
            OP_RD2:  return 3'd2;
            OP_RD4:  return 3'd4;
            default: return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/spw_bit_timer.sv
module spw_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div,
    input  logic [DIV_W-1:0] cnt,
    output logic             at_mid,
    output logic             at_last,
    output logic             late_half
);
    localparam int PW = DIV_W + 1;

    logic [PW-1:0] per, half1, cnt_x;

    always_comb begin
        per       = (div == '0) ? PW'(2) : PW'(div) + PW'(1);
        half1     = per - (per >> 1);
        cnt_x     = PW'(cnt);
        at_mid    = (cnt_x == half1);
        at_last   = (cnt_x == per - PW'(1));
        late_half = (cnt_x >= half1);
    end
endmodule

// File: rtl/spw_cs_drive.sv
module spw_cs_drive #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic              in_frame,
    input  logic [CS_W-1:0]   sel,
    input  logic [NUM_CS-1:0] cspol,
    output logic [NUM_CS-1:0] cs_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_o[g] = (in_frame && sel == CS_W'(g)) ? cspol[g] : ~cspol[g];
    end
endmodule

// File: rtl/spw_word_engine.sv
module spw_word_engine
    import spw_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int WORD_MAX  = 128,
    parameter int FRAME_MAX = 4096,
    parameter int DIV_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk_o,
    output logic [NUM_CS-1:0] cs_o,
    output logic              io0_o,
    output logic              io0_oe,
    input  logic [3:0]        io_i
);
    localparam int WL_W = $clog2(WORD_MAX);
    localparam int BL_W = $clog2(WORD_MAX + 1);
    localparam int FR_W = $clog2(FRAME_MAX);
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    typedef struct packed {
        logic [31:0]         clkctl;
        logic [31:0]         devctl;
        logic [31:0]         cmd;
        logic [WORD_MAX-1:0] data;
        logic [WORD_MAX-1:0] rx;
        logic                busy;
        logic                wc;
        logic                in_frame;
        logic [CS_W-1:0]     sel;
        logic [FR_W-1:0]     flen;
        logic [FR_W-1:0]     wdone;
        logic [2:0]          op;
        logic [BL_W-1:0]     left;
        logic [DIV_W-1:0]    cnt;
    } st_t;

    st_t q, d;

    logic                at_mid, at_last, late_half;
    logic [2:0]          lanes;
    logic                is_rd;
    logic [WORD_MAX-1:0] rx_in;
    logic [2:0]          new_op;
    logic [WL_W-1:0]     bit_idx;
    logic                cpol, cpha;
    logic                stat_busy, stat_wc, clk_en;
    logic [NUM_CS-1:0]   cspol;

    spw_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .div       (q.clkctl[DIV_W-1:0]),
        .cnt       (q.cnt),
        .at_mid    (at_mid),
        .at_last   (at_last),
        .late_half (late_half)
    );

    spw_cs_drive #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
        .in_frame (q.in_frame),
        .sel      (q.sel),
        .cspol    (cspol),
        .cs_o     (cs_o)
    );

    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            cspol[i] = q.devctl[LANE_W*i + LANE_CSPOL];
        end
    end

    // Next-state computation
    always_comb begin
        d      = q;
        lanes  = lanes_of(q.op);
        is_rd  = (q.op != OP_WR1);
        new_op = reg_wdata[CMD_OP_LSB +: 3];
        case (lanes)
            3'd2:    rx_in = {q.rx[WORD_MAX-3:0], io_i[1:0]};
            3'd4:    rx_in = {q.rx[WORD_MAX-5:0], io_i};
            default: rx_in = {q.rx[WORD_MAX-2:0], io_i[1]};
        endcase

        if (q.busy && q.clkctl[CLK_EN_BIT]) begin
            if (at_mid && is_rd) d.rx = rx_in;
            if (at_last) begin
                d.cnt = '0;
                if (q.left <= BL_W'(lanes)) begin
                    d.busy = 1'b0;
                    d.wc   = 1'b1;
                    if (is_rd) d.data = d.rx;
                    if (q.wdone == q.flen) begin
                        d.in_frame = 1'b0;
                        d.wdone    = '0;
                    end else begin
                        d.wdone = q.wdone + 1'b1;
                    end
                end else begin
                    d.left = q.left - BL_W'(lanes);
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (reg_we) begin
            case (reg_addr)
                RA_CLK: d.clkctl = reg_wdata;
                RA_DEV: if (!q.busy) d.devctl = reg_wdata;
                RA_CMD: if (!q.busy) begin
                    case (new_op)
                        OP_RD1, OP_WR1, OP_RD2, OP_RD4: begin
                            d.cmd  = reg_wdata;
                            d.busy = 1'b1;
                            d.wc   = 1'b0;
                            d.op   = new_op;
                            d.left = BL_W'(reg_wdata[CMD_WL_LSB +: WL_W]) + 1'b1;
                            d.cnt  = '0;
                            d.rx   = '0;
                            if (!q.in_frame) begin
                                d.in_frame = 1'b1;
                                d.sel      = reg_wdata[CMD_CS_LSB +: CS_W];
                                d.flen     = reg_wdata[FR_W-1:0];
                                d.wdone    = '0;
                            end
                        end
                        OP_END: begin
                            d.cmd      = reg_wdata;
                            d.in_frame = 1'b0;
                            d.wdone    = '0;
                        end
                        default: ;
                    endcase
                end
                RA_STAT: ;
                default: if (!q.busy) d.data[32*int'(reg_addr[1:0]) +: 32] = reg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Outputs
    always_comb begin
        stat_busy = q.busy;
        stat_wc   = q.wc;
        clk_en    = q.clkctl[CLK_EN_BIT];
        cpol      = q.devctl[LANE_W*int'(q.sel) + LANE_CPOL];
        cpha      = q.devctl[LANE_W*int'(q.sel) + LANE_CPHA];
        sclk_o    = q.busy ? (cpol ^ cpha ^ late_half) : cpol;
        bit_idx   = WL_W'(q.left - 1'b1);
        io0_oe    = q.busy && (q.op == OP_WR1);
        io0_o     = io0_oe & q.data[bit_idx];
        case (reg_addr)
            RA_CLK:  reg_rdata = q.clkctl;
            RA_DEV:  reg_rdata = q.devctl;
            RA_CMD:  reg_rdata = q.cmd;
            RA_STAT: reg_rdata = {30'd0, q.wc, q.busy};
            default: reg_rdata = q.data[32*int'(reg_addr[1:0]) +: 32];
        endcase
    end
endmodule

// File: rtl/spw_word_engine_chk.sv
module spw_word_engine_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic              wc,
    input logic              clk_en,
    input logic [NUM_CS-1:0] cspol,
    input logic [NUM_CS-1:0] cs_o,
    input logic              sclk_o,
    input logic              io0_oe
);
    logic [NUM_CS-1:0] act;
    assign act = ~(cs_o ^ cspol);

    // R7
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act) <= 1);

    // R9
    busy_wc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wc);

    // R9
    wc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc) |-> $fell(busy));

    // R3
    clk_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clk_en) |=> $stable(sclk_o));

    // R8
    end_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 3'd2 && reg_wdata[18:16] == 3'd4) |=> (act == '0));

    // R4
    drive_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io0_oe |-> (act != '0));
endmodule

bind spw_word_engine spw_word_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (stat_busy),
    .wc        (stat_wc),
    .clk_en    (clk_en),
    .cspol     (cspol),
    .cs_o      (cs_o),
    .sclk_o    (sclk_o),
    .io0_oe    (io0_oe)
);

// File: tb/test_spw_word_engine.sv
module test_spw_word_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd3;
    logic [31:0] wdata = '0;
    logic [3:0]  io_fix = '0;
    logic        io_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    wire  [31:0] rdata;
    wire         sclk, io0, oe;
    wire  [3:0]  cs;
    wire  [3:0]  io_i = io_rand ? lfsr[3:0] : io_fix;

    int checks = 0, errors = 0, cyc = 0;
    bit mon_en = 1'b0;

    spw_word_engine i_spw_word_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .sclk_o(sclk), .cs_o(cs), .io0_o(io0), .io0_oe(oe), .io_i(io_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;
    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0]  mclk, mdev, mcmd;
    logic [127:0] mdata, mrx, smp;
    bit           mbusy, mwc, mframe, wasb;
    int           msel, mflen, mwords, mlen, mop, mcyc, o;
    int           per, h1, ph, bn, nclk, ln;

    function automatic int period(input logic [31:0] c);
        int dv = int'(c[15:0]);
        return ((dv == 0) ? 1 : dv) + 1;
    endfunction

    function automatic int lanes(input int op);
        return (op == 3) ? 2 : (op == 7) ? 4 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mclk = 0; mdev = 0; mcmd = 0; mdata = 0; mrx = 0; mbusy = 0; mwc = 0;
            mframe = 0; msel = 0; mflen = 0; mwords = 0; mlen = 1; mop = 0; mcyc = 0;
        end else begin
            wasb = mbusy;
            if (mbusy && mclk[31]) begin
                per  = period(mclk);
                h1   = per - per / 2;
                ph   = mcyc % per;
                bn   = mcyc / per;
                ln   = lanes(mop);
                nclk = (mlen + ln - 1) / ln;
                smp  = (ln == 1) ? 128'(io_i[1]) : (ln == 2) ? 128'(io_i[1:0]) : 128'(io_i);
                if (ph == h1 && mop != 2) mrx = (mrx << ln) | smp;
                if (ph == per - 1 && bn == nclk - 1) begin
                    mbusy = 0; mwc = 1;
                    if (mop != 2) mdata = mrx;
                    mwords++;
                    if (mwords == mflen + 1) begin mframe = 0; mwords = 0; end
                end else begin
                    mcyc++;
                end
            end
            if (we) begin
                case (addr)
                    3'd0: mclk = wdata;
                    3'd1: if (!wasb) mdev = wdata;
                    3'd2: if (!wasb) begin
                        o = int'(wdata[18:16]);
                        if (o == 1 || o == 2 || o == 3 || o == 7) begin
                            mcmd = wdata; mbusy = 1; mwc = 0; mop = o;
                            mlen = int'(wdata[25:19]) + 1; mcyc = 0; mrx = 0;
                            if (!mframe) begin
                                mframe = 1; msel = int'(wdata[29:28]);
                                mflen = int'(wdata[11:0]); mwords = 0;
                            end
                        end else if (o == 4) begin
                            mcmd = wdata; mframe = 0; mwords = 0;
                        end
                    end
                    3'd3: ;
                    default: if (!wasb) mdata[32*(int'(addr) - 4) +: 32] = wdata;
                endcase
            end
        end
    end

    // Per-cycle comparison and serial capture
    logic [127:0] cap = '0;
    bit           prev_sclk = 1'b0;
    int           last_edge = 0, prev_edge = 0;
    logic [3:0]   ecs;
    int           cp, chh, mp, mh;

    always @(negedge clk) begin
        #2;
        if (mon_en) begin
            mp  = period(mclk);
            mh  = mp - mp / 2;
            cp  = int'(mdev[8*msel]);
            chh = int'(mdev[8*msel + 2]);
            check("R6 sclk vs model", 128'(sclk),
                  128'(mbusy ? (cp ^ chh ^ int'((mcyc % mp) >= mh)) : cp));
            for (int i = 0; i < 4; i++)
                ecs[i] = (mframe && msel == i) ? mdev[8*i + 1] : ~mdev[8*i + 1];
            check("R7 cs vs model", 128'(cs), 128'(ecs));
            check("R4 line enable vs model", 128'(oe), 128'(mbusy && mop == 2));
            if (mbusy && mop == 2)
                check("R4 line data vs model", 128'(io0), 128'(mdata[mlen - 1 - mcyc / mp]));
            if (addr == 3'd3 && !we)
                check("R9 status vs model", 128'(rdata[1:0]), 128'({mwc, mbusy}));
            if (sclk && !prev_sclk) begin
                cap = {cap[126:0], io0};
                prev_edge = last_edge;
                last_edge = cyc;
            end
            prev_sclk = sclk;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk); we = 1'b1; addr = a; wdata = v;
        @(negedge clk); we = 1'b0; addr = 3'd3;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); addr = a;
        #1 v = rdata;
        #3 addr = 3'd3;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 5000; k++) begin
            rd(3'd3, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [31:0] mkcmd(input int c, input int l, input int op, input int f);
        return (32'(c) << 28) | (32'(l - 1) << 19) | (32'(op) << 16) | 32'(f - 1);
    endfunction

    initial begin
        wait (cyc == 150000);
        errors++;
        $display("FAIL R9 watchdog actual=busy expected=idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [31:0] v;
    logic        s0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        #2;
        // R1
        check("R1 cs after reset", 128'(cs), 128'(4'hF));
        check("R1 sclk after reset", 128'(sclk), 0);
        check("R1 line enable after reset", 128'(oe), 0);
        rd(3'd3, v);
        check("R1 status after reset", 128'(v), 0);

        // R2 ignored operation code
        wr(3'd0, 32'h8000_0003);
        wr(3'd2, mkcmd(0, 8, 5, 1));
        repeat (3) @(negedge clk);
        rd(3'd3, v);
        check("R2 code 5 ignored status", 128'(v), 0);
        check("R2 code 5 ignored cs", 128'(cs), 128'(4'hF));

        // R4 8-bit write, divider 3
        wr(3'd4, 32'h0000_00A5);
        cap = '0;
        wr(3'd2, mkcmd(0, 8, 2, 1));
        wait_idle();
        check("R4 8-bit write bits", 128'(cap[7:0]), 128'(8'hA5));
        check("R3 period with D=3", 128'(last_edge - prev_edge), 4);
        rd(3'd3, v);
        check("R9 word complete after write", 128'(v), 2);
        check("R7 select released after one-word frame", 128'(cs), 128'(4'hF));

        // R4 128-bit write at D=0, R10 writes while busy
        wr(3'd0, 32'h8000_0000);
        wr(3'd7, 32'h0123_4567);
        wr(3'd6, 32'h89AB_CDEF);
        wr(3'd5, 32'h0246_8ACE);
        wr(3'd4, 32'h1357_9BDF);
        cap = '0;
        wr(3'd2, mkcmd(0, 128, 2, 1));
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd2, mkcmd(1, 8, 1, 1));
        wait_idle();
        check("R4 128-bit write order", cap, {32'h0123_4567, 32'h89AB_CDEF, 32'h0246_8ACE, 32'h1357_9BDF});
        check("R3 period with D=0", 128'(last_edge - prev_edge), 2);
        rd(3'd4, v);
        check("R10 data write while busy ignored", 128'(v), 128'(32'h1357_9BDF));
        rd(3'd2, v);
        check("R10 command write while busy ignored", 128'(v), 128'(mkcmd(0, 128, 2, 1)));

        // R5 reads
        wr(3'd0, 32'h8000_0001);
        io_fix = 4'b1010;
        wr(3'd2, mkcmd(0, 8, 7, 1));
        wait_idle();
        rd(3'd4, v);
        check("R5 4-line read", 128'(v), 128'(32'hAA));
        rd(3'd7, v);
        check("R5 upper word cleared", 128'(v), 0);
        io_fix = 4'b0001;
        wr(3'd2, mkcmd(0, 8, 3, 1));
        wait_idle();
        rd(3'd4, v);
        check("R5 2-line read", 128'(v), 128'(32'h55));
        io_fix = 4'b0010;
        wr(3'd2, mkcmd(0, 5, 1, 1));
        wait_idle();
        rd(3'd4, v);
        check("R5 1-line read on line 1", 128'(v), 128'(32'h1F));
        io_fix = 4'b0011;
        wr(3'd2, mkcmd(0, 12, 7, 1));
        wait_idle();
        rd(3'd4, v);
        check("R5 12-bit 4-line read", 128'(v), 128'(32'h333));
        io_rand = 1'b1;
        wr(3'd2, mkcmd(0, 32, 7, 1));
        wait_idle();
        io_rand = 1'b0;
        rd(3'd4, v);
        check("R5 varying 4-line read", 128'(v), 128'(mdata[31:0]));

        // R6 polarity/phase on select 2, active-high select
        wr(3'd1, 32'h0007_0000);
        wr(3'd4, 32'h0000_BEEF);
        cap = '0;
        wr(3'd2, mkcmd(2, 16, 2, 1));
        repeat (6) @(negedge clk);
        #2 check("R7 active-high select asserted", 128'(cs[2]), 1);
        wait_idle();
        check("R6 mode 3 captured bits", 128'(cap[15:0]), 128'(16'hBEEF));
        check("R6 idle clock level with polarity 1", 128'(sclk), 1);
        wr(3'd1, 32'h0000_0000);

        // R7 three-word frame on select 1
        wr(3'd2, mkcmd(1, 8, 2, 3));
        wait_idle();
        check("R7 held after word 1", 128'(cs), 128'(4'b1101));
        wr(3'd2, mkcmd(1, 8, 2, 3));
        wait_idle();
        check("R7 held after word 2", 128'(cs), 128'(4'b1101));
        wr(3'd2, mkcmd(1, 8, 2, 3));
        wait_idle();
        check("R7 released after word 3", 128'(cs), 128'(4'hF));

        // R8 end-of-frame command
        wr(3'd2, mkcmd(3, 8, 2, 4));
        wait_idle();
        check("R8 select held mid frame", 128'(cs), 128'(4'b0111));
        wr(3'd2, mkcmd(0, 1, 4, 1));
        #2 check("R8 select released by end code", 128'(cs), 128'(4'hF));

        // R9 word-complete clears on next command
        wr(3'd2, mkcmd(0, 8, 2, 1));
        rd(3'd3, v);
        check("R9 busy set, complete cleared", 128'(v), 1);
        wait_idle();
        rd(3'd3, v);
        check("R9 complete after word", 128'(v), 2);

        // R3 clock enable off freezes transfer
        wr(3'd0, 32'h8000_0002);
        wr(3'd2, mkcmd(0, 32, 2, 1));
        repeat (10) @(negedge clk);
        wr(3'd0, 32'h0000_0002);
        #2 s0 = sclk;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            #2 check("R3 clock frozen while disabled", 128'(sclk), 128'(s0));
        end
        rd(3'd3, v);
        check("R3 still busy while disabled", 128'(v), 1);
        wr(3'd0, 32'h8000_0002);
        wait_idle();
        rd(3'd3, v);
        check("R3 completes after re-enable", 128'(v), 2);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule